// File: doc/BRIEF.md
# Virtual GPIO Bank with Interrupt Aggregation

This block is a register-mapped bank of 128 general-purpose pins. Every pin owns one 32-bit configuration word holding the value it drives, whether its driver is off, whether its receiver is off, and which kind of input event it reports. Pin inputs are brought into the clock domain through a two-stage synchronizer. An event detector for each pin then raises a status bit when its input shows a rising edge or holds an active-high level, depending on the mode.

Status bits, enable bits and lock bits are packed 32 pins to a word. One interrupt output is raised while any status bit has its enable bit set. Lock bits come from a strap input during reset and freeze the configuration of their pins.

Software reaches the bank through a single-cycle request bus. Writes take effect at the clock edge that accepts them. Reads return data one cycle later, together with a response strobe.

Top module: `vgpio_bank`

## Requirements
- R1: After reset every configuration word reads 0x0280_0008 with bit 1 showing the input, all enable and status words read zero, the interrupt output is low and no pin driver is on.
- R2: In a configuration word, bit 0 is the value on `pin_out` and bit 3 set turns the driver off (`pin_oe` low). Only bits 0, 3, 4 and 25:22 are stored; bit 1 and all other bits ignore writes, and the unstored bits other than bit 1 read as zero.
- R3: Configuration bit 1 reads the synchronized input level while bit 4 (receiver off) is clear, and reads zero while bit 4 is set.
- R4: With mode field 25:22 equal to 1, a rising input edge sets the pin's status bit once. A falling edge sets nothing, and a high input does not set the bit again after it is cleared.
- R5: With mode field equal to 0, the status bit is set on every cycle that the input is high and the receiver is on, so a clear does not hold while the input stays high.
- R6: Any mode value other than 0 or 1, or a set receiver-off bit, produces no events. This includes the reset value 0xA and the value 2.
- R7: Lock bits are captured from `lock_strap` during reset and read back from lock words at 0x200 + 4·w. Lock words ignore writes, and a configuration write to a locked pin leaves its word unchanged.
- R8: A status word write clears each bit written as 0 and leaves each bit written as 1. An event arriving in the same cycle as its clear keeps the bit set.
- R9: `gpio_irq` is high exactly while some status bit and its enable bit are both set. A status bit still latches while its enable bit is 0. The enable words at 0x240 + 4·w can be written and read back.
- R10: A read request produces `rsp_valid` one cycle later with the data. Addresses outside the four regions read zero.
- R11: Pin p has its configuration word at byte address 4·p. Its status, enable and lock bits are bit p mod 32 of word p/32 in their regions: status at 0x220, enable at 0x240, lock at 0x200.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| lock_strap | input | 128 | Lock bits captured during reset |
| pin_in | input | 128 | Asynchronous pin input levels |
| pin_out | output | 128 | Driven pin values |
| pin_oe | output | 128 | Pin driver enables |
| gpio_irq | output | 1 | Combined interrupt request |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 10 | Byte address, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |

## Verification
The assertions assume three things about the inputs. `lock_strap` holds steady while the bank runs. Bus addresses are word aligned. A request lasts exactly one cycle, with `req_valid` held low throughout reset. The stimulus drives every bus request for a single cycle between falling clock edges and fixes the strap before reset. It changes `pin_in` freely, since the synchronizer absorbs any timing. For the same-cycle race of R8, the bench counts the synchronizer and detector stages and times a clear to land on the edge that carries a new event.

// File: rtl/vgpio_pkg.sv
package vgpio_pkg;

    localparam int unsigned REG_W     = 32;
    localparam int unsigned LOCK_BASE = 'h200;
    localparam int unsigned STAT_BASE = 'h220;
    localparam int unsigned ENAB_BASE = 'h240;

    localparam int unsigned DRIVE_BIT  = 0;
    localparam int unsigned SENSE_BIT  = 1;
    localparam int unsigned DRVOFF_BIT = 3;
    localparam int unsigned RXOFF_BIT  = 4;
    localparam int unsigned MODE_LSB   = 22;
    localparam int unsigned MODE_W     = 4;

    localparam logic [MODE_W-1:0] TRIG_LEVEL = 4'd0;
    localparam logic [MODE_W-1:0] TRIG_RISE  = 4'd1;
    localparam logic [MODE_W-1:0] TRIG_NONE  = 4'd2;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              rx_off;
        logic              drv_off;
        logic              drive;
    } pin_cfg_t;

    localparam pin_cfg_t CFG_RESET = '{mode: 4'hA, rx_off: 1'b0, drv_off: 1'b1, drive: 1'b0};

    function automatic logic [REG_W-1:0] cfg_to_word(pin_cfg_t c, logic sense);
        logic [REG_W-1:0] w;
        w                      = '0;
        w[DRIVE_BIT]           = c.drive;
        w[SENSE_BIT]           = sense;
        w[DRVOFF_BIT]          = c.drv_off;
        w[RXOFF_BIT]           = c.rx_off;
        w[MODE_LSB +: MODE_W]  = c.mode;
        return w;
    endfunction

    function automatic pin_cfg_t word_to_cfg(logic [REG_W-1:0] w);
        pin_cfg_t c;
        c.drive   = w[DRIVE_BIT];
        c.drv_off = w[DRVOFF_BIT];
        c.rx_off  = w[RXOFF_BIT];
        c.mode    = w[MODE_LSB +: MODE_W];
        return c;
    endfunction

endpackage

// File: rtl/vgpio_sync.sv
module vgpio_sync #(
    parameter int unsigned WIDTH = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] held;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta = async_i;
        st_d.held = st_q.meta;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.held;
endmodule

// File: rtl/vgpio_detect.sv
module vgpio_detect
    import vgpio_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     level_i,
    input  pin_cfg_t cfg_i,
    output logic     sense_o,
    output logic     event_o
);
    logic gated;
    logic prev_d, prev_q;

    always_comb begin
        gated   = level_i & ~cfg_i.rx_off;
        prev_d  = gated;
        event_o = 1'b0;
        case (cfg_i.mode)
            TRIG_LEVEL: event_o = gated;
            TRIG_RISE:  event_o = gated & ~prev_q;
            default:    event_o = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= prev_d;
    end

    assign sense_o = gated;
endmodule

// File: rtl/vgpio_irq_merge.sv
module vgpio_irq_merge #(
    parameter int unsigned NUM_PINS      = 128,
    parameter int unsigned PINS_PER_WORD = 32
) (
    input  logic [NUM_PINS-1:0] stat_i,
    input  logic [NUM_PINS-1:0] enab_i,
    output logic                irq_o
);
    localparam int unsigned NUM_WORDS = NUM_PINS / PINS_PER_WORD;

    logic [NUM_WORDS-1:0] word_pend;

    for (genvar w = 0; w < NUM_WORDS; w++) begin : g_word
        assign word_pend[w] = |(stat_i[w*PINS_PER_WORD +: PINS_PER_WORD]
                              & enab_i[w*PINS_PER_WORD +: PINS_PER_WORD]);
    end

    assign irq_o = |word_pend;
endmodule

// File: rtl/vgpio_bank.sv
module vgpio_bank
    import vgpio_pkg::*;
#(
    parameter int unsigned NUM_PINS      = 128,
    parameter int unsigned PINS_PER_WORD = 32,
    parameter int unsigned ADDR_W        = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_PINS-1:0] lock_strap,
    input  logic [NUM_PINS-1:0] pin_in,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic                gpio_irq,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [REG_W-1:0]    req_wdata,
    output logic                rsp_valid,
    output logic [REG_W-1:0]    rsp_rdata
);
    localparam int unsigned NUM_WORDS = NUM_PINS / PINS_PER_WORD;
    localparam int unsigned IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;
    localparam int unsigned WIDX_W    = (NUM_WORDS > 1) ? $clog2(NUM_WORDS) : 1;
    localparam int unsigned CFG_LIM   = NUM_PINS * 4;
    localparam int unsigned SPAN      = NUM_WORDS * 4;

    typedef struct packed {
        pin_cfg_t [NUM_PINS-1:0] cfg;
        logic [NUM_PINS-1:0]     lock;
        logic [NUM_PINS-1:0]     stat;
        logic [NUM_PINS-1:0]     enab;
        logic                    rvalid;
        logic [REG_W-1:0]        rdata;
    } state_t;

    function automatic logic in_region(logic [ADDR_W-1:0] a, int unsigned base);
        return (32'(a) >= base) && (32'(a) < base + SPAN);
    endfunction

    function automatic logic [WIDX_W-1:0] word_of(logic [ADDR_W-1:0] a, int unsigned base);
        return WIDX_W'((32'(a) - base) >> 2);
    endfunction

    state_t d, q, rst_state;

    logic [NUM_PINS-1:0] sync_lvl;
    logic [NUM_PINS-1:0] sense;
    logic [NUM_PINS-1:0] evt;
    logic [NUM_PINS-1:0] clr_mask;

    logic              cfg_hit, lock_hit, stat_hit, enab_hit;
    logic [IDX_W-1:0]  cfg_idx;
    logic [WIDX_W-1:0] lock_w, stat_w, enab_w;
    logic              do_rd, do_wr;

    // Internal views for the bound checker
    pin_cfg_t [NUM_PINS-1:0] cfg_now;
    logic [NUM_PINS-1:0]     lock_now, stat_now, enab_now;

    // Address decode
    always_comb begin
        do_rd    = req_valid & ~req_write;
        do_wr    = req_valid &  req_write;
        cfg_hit  = 32'(req_addr) < CFG_LIM;
        cfg_idx  = IDX_W'(req_addr >> 2);
        lock_hit = in_region(req_addr, LOCK_BASE);
        stat_hit = in_region(req_addr, STAT_BASE);
        enab_hit = in_region(req_addr, ENAB_BASE);
        lock_w   = word_of(req_addr, LOCK_BASE);
        stat_w   = word_of(req_addr, STAT_BASE);
        enab_w   = word_of(req_addr, ENAB_BASE);
    end

    // Reset image: configs at default, locks from strap
    always_comb begin
        rst_state = '0;
        for (int p = 0; p < NUM_PINS; p++) begin
            rst_state.cfg[p] = CFG_RESET;
        end
        rst_state.lock = lock_strap;
    end

    // Next-state logic
    always_comb begin
        d        = q;
        d.rvalid = do_rd;
        d.rdata  = '0;
        clr_mask = '0;

        if (do_rd) begin
            if (cfg_hit) begin
                d.rdata = cfg_to_word(q.cfg[cfg_idx], sense[cfg_idx]);
            end else if (lock_hit) begin
                d.rdata = REG_W'(q.lock[int'(lock_w)*PINS_PER_WORD +: PINS_PER_WORD]);
            end else if (stat_hit) begin
                d.rdata = REG_W'(q.stat[int'(stat_w)*PINS_PER_WORD +: PINS_PER_WORD]);
            end else if (enab_hit) begin
                d.rdata = REG_W'(q.enab[int'(enab_w)*PINS_PER_WORD +: PINS_PER_WORD]);
            end
        end

        if (do_wr) begin
            if (cfg_hit && !q.lock[cfg_idx]) begin
                d.cfg[cfg_idx] = word_to_cfg(req_wdata);
            end
            if (stat_hit) begin
                clr_mask[int'(stat_w)*PINS_PER_WORD +: PINS_PER_WORD] =
                    ~req_wdata[PINS_PER_WORD-1:0];
            end
            if (enab_hit) begin
                d.enab[int'(enab_w)*PINS_PER_WORD +: PINS_PER_WORD] =
                    req_wdata[PINS_PER_WORD-1:0];
            end
        end

        // New events take priority over a clear in the same cycle
        d.stat = (q.stat & ~clr_mask) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) q <= rst_state;
        else        q <= d;
    end

    vgpio_sync #(.WIDTH(NUM_PINS)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(pin_in),
        .sync_o (sync_lvl)
    );

    for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
        vgpio_detect u_det (
            .clk    (clk),
            .rst_n  (rst_n),
            .level_i(sync_lvl[p]),
            .cfg_i  (q.cfg[p]),
            .sense_o(sense[p]),
            .event_o(evt[p])
        );
        assign pin_out[p] = q.cfg[p].drive;
        assign pin_oe[p]  = ~q.cfg[p].drv_off;
    end

    vgpio_irq_merge #(
        .NUM_PINS     (NUM_PINS),
        .PINS_PER_WORD(PINS_PER_WORD)
    ) u_irq (
        .stat_i(q.stat),
        .enab_i(q.enab),
        .irq_o (gpio_irq)
    );

    assign rsp_valid = q.rvalid;
    assign rsp_rdata = q.rdata;
    assign cfg_now   = q.cfg;
    assign lock_now  = q.lock;
    assign stat_now  = q.stat;
    assign enab_now  = q.enab;
endmodule

// File: rtl/vgpio_bank_chk.sv
module vgpio_bank_chk
    import vgpio_pkg::*;
#(
    parameter int unsigned NUM_PINS      = 128,
    parameter int unsigned PINS_PER_WORD = 32,
    parameter int unsigned ADDR_W        = 10
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    req_valid,
    input logic                    req_write,
    input logic [ADDR_W-1:0]       req_addr,
    input logic                    rsp_valid,
    input logic [REG_W-1:0]        rsp_rdata,
    input logic [NUM_PINS-1:0]     pin_out,
    input logic [NUM_PINS-1:0]     pin_oe,
    input logic                    gpio_irq,
    input pin_cfg_t [NUM_PINS-1:0] cfg_now,
    input logic [NUM_PINS-1:0]     lock_now,
    input logic [NUM_PINS-1:0]     stat_now,
    input logic [NUM_PINS-1:0]     enab_now
);
    localparam int unsigned NUM_WORDS = NUM_PINS / PINS_PER_WORD;
    localparam int unsigned SPAN      = NUM_WORDS * 4;
    localparam int unsigned IDX_W     = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [IDX_W-1:0] idx;
    logic             cfg_wr, stat_wr, rd, gap;

    assign idx     = IDX_W'(req_addr >> 2);
    assign rd      = req_valid && !req_write;
    assign cfg_wr  = req_valid && req_write && (32'(req_addr) < NUM_PINS * 4);
    assign stat_wr = req_valid && req_write && (32'(req_addr) >= STAT_BASE)
                     && (32'(req_addr) < STAT_BASE + SPAN);
    assign gap     = ((32'(req_addr) >= LOCK_BASE + SPAN) && (32'(req_addr) < STAT_BASE))
                   || (32'(req_addr) >= ENAB_BASE + SPAN);

    // R7: strap-loaded locks never change while running
    a_r7_lock_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        $stable(lock_now));

    // R7: a config write to a locked pin leaves its word unchanged
    a_r7_locked_write: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && lock_now[idx]) |=> (cfg_now[$past(idx)] == $past(cfg_now[idx])));

    // R10: each read is answered on the next cycle, and only reads are answered
    a_r10_read_resp: assert property (@(posedge clk) disable iff (!rst_n)
        rd |=> rsp_valid);
    a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !rd |=> !rsp_valid);

    // R10: unmapped reads return zero
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rd && gap) |=> (rsp_rdata == '0));

    // R9: with every enable clear the interrupt stays low
    a_r9_masked_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (enab_now == '0) |-> !gpio_irq);

    // R8: status bits fall only through a status write
    a_r8_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !stat_wr |=> ((~stat_now & $past(stat_now)) == '0));

    // R2: pin outputs move only after a write
    a_r2_pins_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_write) |=> $stable({pin_out, pin_oe}));
endmodule

bind vgpio_bank vgpio_bank_chk #(
    .NUM_PINS     (NUM_PINS),
    .PINS_PER_WORD(PINS_PER_WORD),
    .ADDR_W       (ADDR_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_valid(req_valid),
    .req_write(req_write),
    .req_addr (req_addr),
    .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata),
    .pin_out  (pin_out),
    .pin_oe   (pin_oe),
    .gpio_irq (gpio_irq),
    .cfg_now  (cfg_now),
    .lock_now (lock_now),
    .stat_now (stat_now),
    .enab_now (enab_now)
);

// File: tb/vgpio_bank_test.sv
`timescale 1ns/1ps
module vgpio_bank_test;
    localparam int NP = 128;
    localparam int AW = 10;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP-1:0] lock_strap = '0;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pin_out, pin_oe;
    logic          gpio_irq;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [31:0]   req_wdata = '0;
    logic          rsp_valid;
    logic [31:0]   rsp_rdata;

    always #4 clk = ~clk;

    vgpio_bank uut (
        .clk(clk), .rst_n(rst_n), .lock_strap(lock_strap), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .gpio_irq(gpio_irq),
        .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata)
    );

    int          checks = 0;
    int          fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    task automatic check(logic [31:0] act, logic [31:0] exp, string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wait_cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_write(logic [AW-1:0] a, logic [31:0] w);
        req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = w;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    // Driver: queue the expected word and issue the read
    task automatic bus_read(logic [AW-1:0] a, logic [31:0] exp, string tag);
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        req_valid = 1'b1; req_write = 1'b0; req_addr = a;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Monitor: compare every response against the scoreboard
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (exp_q.size() == 0) begin
                check(rsp_rdata, 32'hxxxx_xxxx, "R10 response without request");
            end else begin
                check(rsp_rdata, exp_q.pop_front(), tag_q.pop_front());
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        fails++;
        $display("FAIL watchdog R10: actual hung expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        lock_strap[5]   = 1'b1;
        lock_strap[100] = 1'b1;
        wait_cycles(3);
        rst_n = 1'b1;
        wait_cycles(1);

        // R1 reset state
        bus_read(10'h000, 32'h0280_0008, "R1 cfg0 reset");
        bus_read(10'h240, 32'h0, "R1 enable0 reset");
        bus_read(10'h220, 32'h0, "R1 status0 reset");
        check(32'(gpio_irq), 32'd0, "R1 irq reset");
        check(pin_oe[31:0], 32'h0, "R1 drivers off");

        // R7 / R11 lock words from strap
        bus_read(10'h200, 32'h0000_0020, "R7 lock word0");
        bus_read(10'h20C, 32'h0000_0010, "R11 lock word3 pin100");
        bus_read(10'h204, 32'h0, "R7 lock word1");

        // R2 config fields
        bus_write(10'h01C, 32'h0280_0F03);
        bus_read(10'h01C, 32'h0280_0001, "R2 cfg7 readback");
        check(32'(pin_out[7]), 32'd1, "R2 pin7 value");
        check(32'(pin_oe[7]), 32'd1, "R2 pin7 driver on");
        bus_write(10'h01C, 32'h0280_0008);
        check(32'(pin_oe[7]), 32'd0, "R2 pin7 driver off");

        // R7 locked pin and read-only lock word
        bus_write(10'h014, 32'h0000_0001);
        bus_read(10'h014, 32'h0280_0008, "R7 locked cfg5 unchanged");
        check(32'(pin_oe[5]), 32'd0, "R7 locked pin5 driver");
        bus_write(10'h200, 32'h0);
        bus_read(10'h200, 32'h0000_0020, "R7 lock word write ignored");

        // R3 sampled input
        pin_in[9] = 1'b1;
        wait_cycles(4);
        bus_read(10'h024, 32'h0280_000A, "R3 cfg9 input high");
        bus_write(10'h024, 32'h0280_0018);
        bus_read(10'h024, 32'h0280_0018, "R3 cfg9 receiver off");

        // R4 rising edge, pin 40 = word1 bit8
        bus_write(10'h0A0, 32'h0040_0008);
        bus_write(10'h244, 32'h0000_0100);
        bus_read(10'h244, 32'h0000_0100, "R11 enable word1 readback");
        pin_in[40] = 1'b1;
        wait_cycles(5);
        check(32'(gpio_irq), 32'd1, "R4 edge irq");
        bus_read(10'h224, 32'h0000_0100, "R4 edge status");
        bus_write(10'h224, 32'hFFFF_FEFF);
        wait_cycles(3);
        bus_read(10'h224, 32'h0, "R4 no retrigger while high");
        check(32'(gpio_irq), 32'd0, "R4 irq after clear");
        pin_in[40] = 1'b0;
        wait_cycles(5);
        bus_read(10'h224, 32'h0, "R4 falling edge ignored");

        // R5 level mode, pin 64 = word2 bit0
        bus_write(10'h100, 32'h0000_0008);
        pin_in[64] = 1'b1;
        wait_cycles(5);
        bus_read(10'h228, 32'h0000_0001, "R5 level status");
        bus_write(10'h248, 32'h0000_0001);
        check(32'(gpio_irq), 32'd1, "R5 level irq");
        bus_write(10'h228, 32'hFFFF_FFFE);
        wait_cycles(1);
        bus_read(10'h228, 32'h0000_0001, "R5 clear does not hold");
        pin_in[64] = 1'b0;
        wait_cycles(5);
        bus_write(10'h228, 32'hFFFF_FFFE);
        bus_read(10'h228, 32'h0, "R5 cleared after input low");
        check(32'(gpio_irq), 32'd0, "R5 irq low");

        // R6 disabled detection
        bus_write(10'h104, 32'h0080_0008);
        bus_write(10'h108, 32'h0000_0018);
        pin_in[65] = 1'b1;
        pin_in[66] = 1'b1;
        wait_cycles(5);
        bus_read(10'h228, 32'h0, "R6 mode2 and receiver off silent");

        // R9 masked latch, pin 96 = word3 bit0
        bus_write(10'h180, 32'h0040_0008);
        pin_in[96] = 1'b1;
        wait_cycles(5);
        bus_read(10'h22C, 32'h0000_0001, "R9 latched while masked");
        check(32'(gpio_irq), 32'd0, "R9 masked irq low");
        bus_write(10'h24C, 32'h0000_0001);
        check(32'(gpio_irq), 32'd1, "R9 unmask raises irq");
        bus_write(10'h24C, 32'h0);
        check(32'(gpio_irq), 32'd0, "R9 mask drops irq");

        // R8 write-one leaves bits
        bus_write(10'h22C, 32'hFFFF_FFFF);
        bus_read(10'h22C, 32'h0000_0001, "R8 ones leave status");

        // R8 event wins over a clear in the same cycle, pin 97
        bus_write(10'h184, 32'h0040_0008);
        pin_in[97] = 1'b1;
        @(negedge clk);
        @(negedge clk);
        bus_write(10'h22C, 32'hFFFF_FFFD);
        bus_read(10'h22C, 32'h0000_0003, "R8 event beats clear");

        // R10 unmapped reads
        bus_read(10'h210, 32'h0, "R10 gap after locks");
        bus_read(10'h250, 32'h0, "R10 gap after enables");
        bus_read(10'h3FC, 32'h0, "R10 top of space");

        // R11 last pin
        bus_write(10'h1FC, 32'h0280_0009);
        check(32'(pin_out[127]), 32'd1, "R11 pin127 value");
        check(32'(pin_oe[127]), 32'd0, "R11 pin127 driver off");
        bus_read(10'h1FC, 32'h0280_0009, "R11 cfg127 readback");

        wait_cycles(3);
        check(32'(exp_q.size()), 32'd0, "R10 responses outstanding");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule